// File: doc/BRIEF.md
# Video Memory Write Port with Stepping Address

This block sits between a processor's byte-wide register writes and two on-chip memories. The first is a video memory of 32K words of 16 bits each. The second is a small palette memory. For the video memory, software loads a 15-bit word address one byte at a time and then streams data bytes into the low or high half of each word. After each data write the address moves forward by a programmable step, so software can fill rows, columns or tile planes without reloading the address.

A mode register holds three settings: the step size, the byte lane whose write moves the address forward, and a two-bit remap field. The remap field is only stored and shown on an output; it does not change addressing. The palette side has a byte pointer. Software loads it with an entry index, which the block doubles into a byte address, and each palette data write moves the pointer forward by one byte.

Every register write is one cycle of `reg_wr` together with a select code and a data byte. A data write produces its memory strobe, byte address and data in that same cycle, combinationally. Any pointer update takes effect at the following clock edge.

Top module: `vram_port_ctrl`

## Requirements
- R1: After reset the word address is 0, the step is +1, the low-byte write advances the address, the remap output is 0 and the palette pointer is 0. No strobe is driven while reset is held.
- R2: Mode bits 1:0 set the step in words: 0 gives +1, 1 gives +32, and 2 or 3 give +128.
- R3: Mode bit 7 picks the advancing lane. When it is 0 only a low-byte data write advances the address. When it is 1 only a high-byte data write advances it. A data write in the other lane leaves the address unchanged.
- R4: An address-low write replaces word address bits 7:0. An address-high write replaces bits 14:8 with data bits 6:0. Data bit 7 is ignored, and the bits of the other half are kept.
- R5: The word address wraps modulo 2^15 when it advances.
- R6: A low-byte data write drives `vram_byte_addr` = 2×word. A high-byte data write drives 2×word+1. In both cases `vram_wdata` is the written byte.
- R7: Mode bits 3:2 appear on `remap_mode` after a mode write and have no effect on the byte addresses produced.
- R8: A palette-address write sets the palette byte pointer to the written value × 2.
- R9: Each palette data write drives `pal_we` with `pal_byte_addr` = the pointer and `pal_wdata` = the byte. The pointer then advances by 1 and wraps at 512. Video data writes do not move it.
- R10: Select codes: 0 mode, 1 address low, 2 address high, 3 video data low, 4 video data high, 5 palette address, 6 palette data. Code 7 is unused. A strobe appears in the same cycle as the `reg_wr` of a data write, and at no other time. Code 7 has no effect, and at most one strobe is active at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write, one cycle per write |
| reg_sel | input | 3 | Register select code (see R10) |
| reg_wdata | input | 8 | Register write data |
| vram_we | output | 1 | Video memory byte write strobe |
| vram_byte_addr | output | 16 | Video memory byte address |
| vram_wdata | output | 8 | Video memory write byte |
| pal_we | output | 1 | Palette memory byte write strobe |
| pal_byte_addr | output | 9 | Palette memory byte address |
| pal_wdata | output | 8 | Palette memory write byte |
| remap_mode | output | 2 | Stored remap field from the mode register |

## Verification
The bound checker watches every cycle for the following:
- strobes stay mutually exclusive and only follow a data write;
- the lane bit and word field of the byte address match the decoded select and the held address;
- each advance adds the step chosen by the mode, wrapping modulo 2^15;
- a write in the non-advancing lane leaves the address alone;
- address-high, mode and palette-address loads land as specified.

The reset values, including step +1 and low-lane advance, can only be shown through the bench's scenarios. So can the actual data bytes, the wrap points at 0x7FFF and at palette byte 511, and the rule that the remap field leaves the address sequence unchanged. The bench's scoreboard compares each strobe against an independently kept address model.

// File: rtl/vport_pkg.sv
package vport_pkg;

  localparam int SEL_W   = 3;
  localparam int NUM_SEL = 7;

  localparam int IDX_MODE     = 0;
  localparam int IDX_ADDR_LO  = 1;
  localparam int IDX_ADDR_HI  = 2;
  localparam int IDX_DATA_LO  = 3;
  localparam int IDX_DATA_HI  = 4;
  localparam int IDX_PAL_ADDR = 5;
  localparam int IDX_PAL_DATA = 6;

  localparam logic [SEL_W-1:0] SEL_ADDR_HI  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_MODE     = 3'd0;
  localparam logic [SEL_W-1:0] SEL_DATA_HI  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_PAL_ADDR = 3'd5;
  localparam logic [SEL_W-1:0] SEL_UNUSED   = 3'd7;

  // Mode field positions: these are decoded by software, so they stay fixed.
  localparam int STEP_LSB  = 0;
  localparam int REMAP_LSB = 2;
  localparam int REMAP_W   = 2;

  // Step in words for a two-bit step code.
  function automatic logic [31:0] step_words(input logic [1:0] code,
                                             input int mid_log2,
                                             input int big_log2);
    logic [31:0] s;
    case (code)
      2'd0:    s = 32'd1;
      2'd1:    s = 32'd1 << mid_log2;
      default: s = 32'd1 << big_log2;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/vport_decode.sv
module vport_decode
  import vport_pkg::*;
(
  input  logic              reg_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  output logic [NUM_SEL-1:0] hit
);
  for (genvar i = 0; i < NUM_SEL; i++) begin : g_hit
    assign hit[i] = reg_wr && (reg_sel == SEL_W'(i));
  end
endmodule

// File: rtl/vport_word_addr.sv
module vport_word_addr
  import vport_pkg::*;
#(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int MID_LOG2 = 5,
  parameter int BIG_LOG2 = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_mode,
  input  logic               ev_addr_lo,
  input  logic               ev_addr_hi,
  input  logic               ev_data_lo,
  input  logic               ev_data_hi,
  input  logic [DW-1:0]      wdata,
  output logic [AW-1:0]      word_q,
  output logic [1:0]         step_code_q,
  output logic               inc_on_hi_q,
  output logic [REMAP_W-1:0] remap_q,
  output logic               adv
);
  localparam int HI_W = AW - DW;

  logic [AW-1:0] step_val;

  assign adv      = inc_on_hi_q ? ev_data_hi : ev_data_lo;
  assign step_val = AW'(step_words(step_code_q, MID_LOG2, BIG_LOG2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_code_q <= '0;
      inc_on_hi_q <= 1'b0;
      remap_q     <= '0;
    end else if (ev_mode) begin
      step_code_q <= wdata[STEP_LSB +: 2];
      inc_on_hi_q <= wdata[DW-1];
      remap_q     <= wdata[REMAP_LSB +: REMAP_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (ev_addr_lo) begin
      word_q[DW-1:0] <= wdata;
    end else if (ev_addr_hi) begin
      word_q[AW-1:DW] <= wdata[HI_W-1:0];
    end else if (adv) begin
      word_q <= word_q + step_val;
    end
  end
endmodule

// File: rtl/vport_pal_ptr.sv
module vport_pal_ptr #(
  parameter int PAW = 9,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ev_load,
  input  logic           ev_write,
  input  logic [DW-1:0]  wdata,
  output logic [PAW-1:0] ptr_q
);
  localparam int LOAD_W = DW + 1;

  logic [LOAD_W-1:0] load_val;
  assign load_val = {wdata, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (ev_load)  ptr_q <= PAW'(load_val);
    else if (ev_write) ptr_q <= ptr_q + PAW'(1);
  end
endmodule

// File: rtl/vram_port_ctrl.sv
module vram_port_ctrl
  import vport_pkg::*;
#(
  parameter int WORD_AW       = 15,
  parameter int DATA_W        = 8,
  parameter int PAL_AW        = 9,
  parameter int MID_STEP_LOG2 = 5,
  parameter int BIG_STEP_LOG2 = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [2:0]         reg_sel,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic               vram_we,
  output logic [WORD_AW:0]   vram_byte_addr,
  output logic [DATA_W-1:0]  vram_wdata,
  output logic               pal_we,
  output logic [PAL_AW-1:0]  pal_byte_addr,
  output logic [DATA_W-1:0]  pal_wdata,
  output logic [1:0]         remap_mode
);
  logic [NUM_SEL-1:0]  hit;
  logic [WORD_AW-1:0]  word_q;
  logic [1:0]          step_code_q;
  logic                inc_on_hi_q;
  logic [REMAP_W-1:0]  remap_q;
  logic                adv;
  logic [PAL_AW-1:0]   pal_ptr;

  vport_decode u_dec (
    .reg_wr  (reg_wr),
    .reg_sel (reg_sel),
    .hit     (hit)
  );

  vport_word_addr #(
    .AW(WORD_AW), .DW(DATA_W), .MID_LOG2(MID_STEP_LOG2), .BIG_LOG2(BIG_STEP_LOG2)
  ) u_word (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_mode     (hit[IDX_MODE]),
    .ev_addr_lo  (hit[IDX_ADDR_LO]),
    .ev_addr_hi  (hit[IDX_ADDR_HI]),
    .ev_data_lo  (hit[IDX_DATA_LO]),
    .ev_data_hi  (hit[IDX_DATA_HI]),
    .wdata       (reg_wdata),
    .word_q      (word_q),
    .step_code_q (step_code_q),
    .inc_on_hi_q (inc_on_hi_q),
    .remap_q     (remap_q),
    .adv         (adv)
  );

  vport_pal_ptr #(.PAW(PAL_AW), .DW(DATA_W)) u_pal (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_load  (hit[IDX_PAL_ADDR]),
    .ev_write (hit[IDX_PAL_DATA]),
    .wdata    (reg_wdata),
    .ptr_q    (pal_ptr)
  );

  assign vram_we        = hit[IDX_DATA_LO] | hit[IDX_DATA_HI];
  assign vram_byte_addr = {word_q, hit[IDX_DATA_HI]};
  assign vram_wdata     = reg_wdata;
  assign pal_we         = hit[IDX_PAL_DATA];
  assign pal_byte_addr  = pal_ptr;
  assign pal_wdata      = reg_wdata;
  assign remap_mode     = remap_q;
endmodule

// File: rtl/vport_checker.sv
module vport_checker
  import vport_pkg::*;
#(
  parameter int AW       = 15,
  parameter int DW       = 8,
  parameter int PAW      = 9,
  parameter int MID_LOG2 = 5,
  parameter int BIG_LOG2 = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [2:0]     reg_sel,
  input logic [DW-1:0]  reg_wdata,
  input logic           vram_we,
  input logic [AW:0]    vram_byte_addr,
  input logic           pal_we,
  input logic [PAW-1:0] pal_byte_addr,
  input logic [1:0]     remap_mode,
  input logic [AW-1:0]  word_q,
  input logic [1:0]     step_code_q,
  input logic           inc_on_hi_q,
  input logic           adv,
  input logic [PAW-1:0] pal_ptr
);
  logic [AW-1:0] exp_step;
  always_comb begin
    case (step_code_q)
      2'd0:    exp_step = AW'(1);
      2'd1:    exp_step = AW'(1) << MID_LOG2;
      default: exp_step = AW'(1) << BIG_LOG2;
    endcase
  end

  assert_strobe_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vram_we, pal_we}));

  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |-> (!vram_we && !pal_we));

  assert_unused_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_UNUSED) |=> $stable(word_q) && $stable(pal_ptr));

  assert_lane_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> (vram_byte_addr[0] == (reg_sel == SEL_DATA_HI)));

  assert_word_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |-> (vram_byte_addr[AW:1] == word_q));

  // Step size per mode, with modulo 2^AW wrap (R5).
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (word_q == $past(word_q + exp_step)));

  assert_lane_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (vram_we && vram_byte_addr[0] == inc_on_hi_q));

  assert_other_lane_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vram_we && !adv) |=> $stable(word_q));

  assert_addr_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_ADDR_HI) |=>
      (word_q[AW-1:DW] == $past(reg_wdata[AW-DW-1:0])) &&
      (word_q[DW-1:0] == $past(word_q[DW-1:0])));

  assert_remap_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_MODE) |=>
      (remap_mode == $past(reg_wdata[REMAP_LSB +: REMAP_W])) &&
      (step_code_q == $past(reg_wdata[1:0])));

  assert_pal_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == SEL_PAL_ADDR) |=> (pal_ptr == PAW'({$past(reg_wdata), 1'b0})));

  assert_pal_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |=> (pal_ptr == $past(pal_byte_addr) + PAW'(1)));

  assert_pal_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vram_we |=> $stable(pal_ptr));
endmodule

bind vram_port_ctrl vport_checker #(
  .AW(WORD_AW), .DW(DATA_W), .PAW(PAL_AW),
  .MID_LOG2(MID_STEP_LOG2), .BIG_LOG2(BIG_STEP_LOG2)
) u_vport_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr         (reg_wr),
  .reg_sel        (reg_sel),
  .reg_wdata      (reg_wdata),
  .vram_we        (vram_we),
  .vram_byte_addr (vram_byte_addr),
  .pal_we         (pal_we),
  .pal_byte_addr  (pal_byte_addr),
  .remap_mode     (remap_mode),
  .word_q         (word_q),
  .step_code_q    (step_code_q),
  .inc_on_hi_q    (inc_on_hi_q),
  .adv            (adv),
  .pal_ptr        (pal_ptr)
);

// File: tb/tb_vram_port_ctrl.sv
`timescale 1ns/1ps
module tb_vram_port_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       reg_wr = 1'b0;
  logic [2:0] reg_sel = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic        vram_we, pal_we;
  logic [15:0] vram_byte_addr;
  logic [8:0]  pal_byte_addr;
  logic [7:0]  vram_wdata, pal_wdata;
  logic [1:0]  remap_mode;

  vram_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .vram_we(vram_we), .vram_byte_addr(vram_byte_addr), .vram_wdata(vram_wdata),
    .pal_we(pal_we), .pal_byte_addr(pal_byte_addr), .pal_wdata(pal_wdata),
    .remap_mode(remap_mode)
  );

  int total = 0;
  int bad = 0;

  // Bench model of the pointers.
  logic [14:0] m_word = '0;
  int          m_step = 1;
  bit          m_hi = 1'b0;
  logic [8:0]  m_pal = '0;

  // Scoreboard queues: kind 0 = video, 1 = palette.
  bit         q_kind[$];
  int         q_addr[$];
  logic [7:0] q_data[$];
  string      q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input bit k, input int a, input logic [7:0] d, input string t);
    q_kind.push_back(k); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  // Driver: updates the model, queues the expected strobe, issues one write.
  task automatic put(input logic [2:0] sel, input logic [7:0] d, input string t);
    case (sel)
      3'd0: begin
        m_step = (d[1:0] == 2'd0) ? 1 : (d[1:0] == 2'd1) ? 32 : 128;
        m_hi = d[7];
      end
      3'd1: m_word[7:0] = d;
      3'd2: m_word[14:8] = d[6:0];
      3'd3: begin
        push(1'b0, {16'd0, m_word, 1'b0}, d, t);
        if (!m_hi) m_word = m_word + 15'(m_step);
      end
      3'd4: begin
        push(1'b0, {16'd0, m_word, 1'b1}, d, t);
        if (m_hi) m_word = m_word + 15'(m_step);
      end
      3'd5: m_pal = {d, 1'b0};
      3'd6: begin
        push(1'b1, {23'd0, m_pal}, d, t);
        m_pal = m_pal + 9'd1;
      end
      default: ;
    endcase
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  // A cycle that must produce no strobe.
  task automatic idle(input bit wr, input logic [2:0] sel, input string t);
    reg_sel = sel; reg_wdata = 8'hFF; reg_wr = wr;
    @(negedge clk);
    check(!vram_we && !pal_we, t, "strobe on non-data cycle",
          {vram_we, pal_we}, 0);
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  // Monitor: pops and compares each strobe away from the clock edge.
  always @(negedge clk) begin
    if (rst_n && (vram_we || pal_we)) begin
      if (q_kind.size() == 0) begin
        check(1'b0, "R10", "unexpected strobe", {vram_we, pal_we}, 0);
      end else begin
        bit k; int a; logic [7:0] d; string t;
        int act_a; logic [7:0] act_d;
        k = q_kind.pop_front(); a = q_addr.pop_front();
        d = q_data.pop_front(); t = q_tag.pop_front();
        act_a = pal_we ? int'(pal_byte_addr) : int'(vram_byte_addr);
        act_d = pal_we ? pal_wdata : vram_wdata;
        check(pal_we == k && (vram_we != pal_we), t, "strobe kind",
              {vram_we, pal_we}, k ? 1 : 2);
        check(act_a == a, t, "byte address", act_a, a);
        check(act_d == d, t, "write data", act_d, d);
      end
    end
  end

  initial begin : watchdog
    #400000;
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!vram_we && !pal_we, "R1", "strobe in reset", {vram_we, pal_we}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(remap_mode == 2'd0, "R1", "remap after reset", remap_mode, 0);
    @(posedge clk); #1;

    // R1: reset address 0, step +1, low lane advances.
    put(3'd3, 8'hA1, "R1");
    put(3'd3, 8'hA2, "R1");
    put(3'd4, 8'h5C, "R6");
    put(3'd4, 8'h5D, "R3");

    // R4: byte-wise address load, bit 7 of high byte dropped.
    put(3'd1, 8'h34, "R4");
    put(3'd2, 8'hD2, "R4");
    put(3'd4, 8'h11, "R4");
    put(3'd3, 8'h22, "R6");
    put(3'd3, 8'h33, "R3");

    // R2/R3: +32, high lane advances.
    put(3'd0, 8'h81, "R2");
    put(3'd3, 8'h44, "R3");
    put(3'd4, 8'h55, "R2");
    put(3'd4, 8'h66, "R2");

    // R2: codes 2 and 3 both give +128.
    put(3'd0, 8'h82, "R2");
    put(3'd4, 8'h77, "R2");
    put(3'd4, 8'h78, "R2");
    put(3'd0, 8'h03, "R2");
    put(3'd3, 8'h79, "R2");
    put(3'd3, 8'h7A, "R2");

    // R5: wrap with +128 and with +1.
    put(3'd1, 8'hFF, "R5");
    put(3'd2, 8'h7F, "R5");
    put(3'd3, 8'h81, "R5");
    put(3'd3, 8'h82, "R5");
    put(3'd0, 8'h00, "R5");
    put(3'd1, 8'hFF, "R5");
    put(3'd2, 8'hFF, "R5");
    put(3'd3, 8'h83, "R5");
    put(3'd3, 8'h84, "R5");

    // R7: remap stored, address sequence unchanged.
    put(3'd0, 8'h0C, "R7");
    @(negedge clk);
    check(remap_mode == 2'd3, "R7", "remap field", remap_mode, 3);
    @(posedge clk); #1;
    put(3'd3, 8'h91, "R7");
    put(3'd3, 8'h92, "R7");
    put(3'd0, 8'h84, "R7");
    @(negedge clk);
    check(remap_mode == 2'd1, "R7", "remap field", remap_mode, 1);
    @(posedge clk); #1;
    put(3'd3, 8'h93, "R7");
    put(3'd4, 8'h94, "R7");

    // R8/R9: palette pointer load and increment with wrap.
    put(3'd5, 8'h10, "R8");
    put(3'd6, 8'hC1, "R8");
    put(3'd6, 8'hC2, "R9");
    put(3'd3, 8'hC3, "R9");
    put(3'd6, 8'hC4, "R9");
    put(3'd5, 8'hFF, "R8");
    put(3'd6, 8'hC5, "R9");
    put(3'd6, 8'hC6, "R9");
    put(3'd6, 8'hC7, "R9");

    // R10: idle and unused select produce nothing and change nothing.
    idle(1'b0, 3'd3, "R10");
    idle(1'b0, 3'd6, "R10");
    idle(1'b1, 3'd7, "R10");
    put(3'd3, 8'hD1, "R10");
    put(3'd6, 8'hD2, "R10");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(q_kind.size() == 0, "R10", "missing strobes", q_kind.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule